// File: doc/BRIEF.md
# Byte-Stream Acquisition Command Decoder

This block sits behind a byte receiver, typically a UART. It watches the received bytes for fixed 32-bit control words that start, stop or reset data acquisition. Every valid byte enters a sliding window on the right, so the newest byte is the least significant. The full window is compared against two families of command codes. One family is the set used on the serial link. The other is the set used on the network path, so a processor can forward network commands into the same byte interface.

A start word raises a level capture-enable output and keeps it high. A stop word lowers it. A reset word lowers it and also issues a single-cycle pulse that resets the acquisition logic. When a word matches, the window is emptied, so the next command needs four new bytes. Any byte sequence that is not a command changes nothing.

Top module: `cmd_decoder`

## Requirements
- R1: While `rst` is high, `captureEn` and `acqResetPulse` are 0 and the byte window is emptied. Bytes received before a reset therefore cannot combine with bytes received after it to form a command.
- R2: Bytes are taken most significant first, on each clock where `rxValid` is 1. A command is recognized no matter how many unrelated bytes come before it.
- R3: The start words are 0xAA55EEA0 (serial) and 0xAA55FFA0 (network). A start word sets `captureEn` to 1 on the clock edge that accepts its last byte, and `captureEn` stays 1 afterwards.
- R4: The stop words are 0xAA55EEB1 and 0xAA55FFB1. A stop word clears `captureEn` on the clock edge that accepts its last byte.
- R5: The reset words are 0xAA55EEC1 and 0xAA55FFC1. A reset word clears `captureEn` and drives `acqResetPulse` high for exactly one cycle, starting at the edge that accepts its last byte.
- R6: A start word while capture is already enabled, or a stop word while it is disabled, leaves `captureEn` unchanged and produces no pulse.
- R7: After any match, the window is empty. The next command is recognized only on the fourth byte received after the match, and not before.
- R8: A byte with `rxValid` at 0 is ignored, and gaps may appear inside a command. A four-byte pattern that is not one of the six words (for example 0xAA55EEC0) leaves both outputs unchanged.
- R9: Network words act exactly like the matching serial words, and the two families may be used in any mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxValid | input | 1 | `rxByte` holds a received byte this cycle |
| rxByte | input | 8 | Received byte |
| captureEn | output | 1 | Level enable for acquisition |
| acqResetPulse | output | 1 | One-cycle reset request for acquisition logic |

## Verification
The hardest case to reach from the ports is showing that a partly received command is really thrown away. This covers a reset that arrives in the middle of a word, and a word whose first bytes are split by idle cycles or by a near-miss pattern. The stimulus stops a start word one byte short, asserts reset, and then sends only the final byte; the enable must stay low. Idle gaps with garbage on `rxByte` are placed inside a start word, and a pattern that differs from a real command only in its last byte is sent while capture is enabled, to show that the enable holds.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int BYTE_W    = 8;
  localparam int CMD_BYTES = 4;
  localparam int NUM_FAM   = 2;
  localparam int WIN_W     = BYTE_W * CMD_BYTES;

  // Family 0: serial link words; family 1: network-forwarded words.
  localparam logic [NUM_FAM*WIN_W-1:0] DEF_START = {32'hAA55FFA0, 32'hAA55EEA0};
  localparam logic [NUM_FAM*WIN_W-1:0] DEF_STOP  = {32'hAA55FFB1, 32'hAA55EEB1};
  localparam logic [NUM_FAM*WIN_W-1:0] DEF_RESET = {32'hAA55FFC1, 32'hAA55EEC1};

  // Datapath -> control: which command completed with the current byte.
  typedef struct packed {
    logic start;
    logic stop;
    logic reset;
  } cmd_hit_t;

  // Control -> datapath strobes.
  typedef struct packed {
    logic clearWin;
  } ctl_strobe_t;
endpackage

// File: rtl/cmd_window.sv
module cmd_window
  import cmd_dec_pkg::*;
#(
  parameter int BYTE_W    = cmd_dec_pkg::BYTE_W,
  parameter int CMD_BYTES = cmd_dec_pkg::CMD_BYTES,
  parameter int NUM_FAM   = cmd_dec_pkg::NUM_FAM,
  parameter int WIN_W     = BYTE_W * CMD_BYTES,
  parameter logic [NUM_FAM*WIN_W-1:0] START_CODES = cmd_dec_pkg::DEF_START,
  parameter logic [NUM_FAM*WIN_W-1:0] STOP_CODES  = cmd_dec_pkg::DEF_STOP,
  parameter logic [NUM_FAM*WIN_W-1:0] RESET_CODES = cmd_dec_pkg::DEF_RESET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  ctl_strobe_t       ctl,
  output cmd_hit_t          hits
);
  logic [WIN_W-1:0]   win;
  logic [WIN_W-1:0]   nextWin;
  logic [NUM_FAM-1:0] startVec, stopVec, resetVec;

  // Newest byte enters at the least significant end.
  assign nextWin = {win[WIN_W-BYTE_W-1:0], rxByte};

  for (genvar f = 0; f < NUM_FAM; f++) begin : g_fam
    assign startVec[f] = rxValid && (nextWin == START_CODES[f*WIN_W +: WIN_W]);
    assign stopVec[f]  = rxValid && (nextWin == STOP_CODES [f*WIN_W +: WIN_W]);
    assign resetVec[f] = rxValid && (nextWin == RESET_CODES[f*WIN_W +: WIN_W]);
  end

  always_comb begin
    hits.start = |startVec;
    hits.stop  = |stopVec;
    hits.reset = |resetVec;
  end

  always_ff @(posedge clk) begin
    if (rst)               win <= '0;
    else if (ctl.clearWin) win <= '0;
    else if (rxValid)      win <= nextWin;
  end

  // R2: an accepted byte that completes nothing lands at the low end
  a_r2_byte_shift_in: assert property (@(posedge clk) disable iff (rst)
    (rxValid && !ctl.clearWin) |=> (win[BYTE_W-1:0] == $past(rxByte)));

  // R7: a completed command leaves an empty window
  a_r7_window_empty_after_hit: assert property (@(posedge clk) disable iff (rst)
    (hits.start || hits.stop || hits.reset) |=> (win == '0));

  // R8: idle cycles do not move the window
  a_r8_idle_window_stable: assert property (@(posedge clk) disable iff (rst)
    !rxValid |=> $stable(win));
endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import cmd_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  cmd_hit_t    hits,
  output ctl_strobe_t ctl,
  output logic        captureEn,
  output logic        acqResetPulse
);
  logic anyHit;

  assign anyHit       = hits.start || hits.stop || hits.reset;
  assign ctl.clearWin = anyHit;

  // Priority reset > stop > start; codes are distinct so at most one fires.
  always_ff @(posedge clk) begin
    if (rst) begin
      captureEn     <= 1'b0;
      acqResetPulse <= 1'b0;
    end else begin
      acqResetPulse <= hits.reset;
      if (hits.reset || hits.stop) captureEn <= 1'b0;
      else if (hits.start)         captureEn <= 1'b1;
    end
  end

  a_r3_start_sets_enable: assert property (@(posedge clk) disable iff (rst)
    hits.start |=> captureEn);

  a_r4_stop_clears_enable: assert property (@(posedge clk) disable iff (rst)
    hits.stop |=> !captureEn);

  a_r5_pulse_single_cycle: assert property (@(posedge clk) disable iff (rst)
    acqResetPulse |=> !acqResetPulse);

  a_r5_pulse_with_enable_low: assert property (@(posedge clk) disable iff (rst)
    acqResetPulse |-> !captureEn);

  a_r8_no_hit_holds_state: assert property (@(posedge clk) disable iff (rst)
    !anyHit |=> ($stable(captureEn) && !acqResetPulse));

  a_r5_at_most_one_hit: assert property (@(posedge clk) disable iff (rst)
    $countones({hits.start, hits.stop, hits.reset}) <= 1);
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter int BYTE_W    = cmd_dec_pkg::BYTE_W,
  parameter int CMD_BYTES = cmd_dec_pkg::CMD_BYTES,
  parameter int NUM_FAM   = cmd_dec_pkg::NUM_FAM,
  parameter logic [NUM_FAM*BYTE_W*CMD_BYTES-1:0] START_CODES = cmd_dec_pkg::DEF_START,
  parameter logic [NUM_FAM*BYTE_W*CMD_BYTES-1:0] STOP_CODES  = cmd_dec_pkg::DEF_STOP,
  parameter logic [NUM_FAM*BYTE_W*CMD_BYTES-1:0] RESET_CODES = cmd_dec_pkg::DEF_RESET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              captureEn,
  output logic              acqResetPulse
);
  localparam int WIN_W = BYTE_W * CMD_BYTES;

  cmd_hit_t    hits;
  ctl_strobe_t ctl;

  cmd_window #(
    .BYTE_W     (BYTE_W),
    .CMD_BYTES  (CMD_BYTES),
    .NUM_FAM    (NUM_FAM),
    .WIN_W      (WIN_W),
    .START_CODES(START_CODES),
    .STOP_CODES (STOP_CODES),
    .RESET_CODES(RESET_CODES)
  ) u_window (
    .clk    (clk),
    .rst    (rst),
    .rxValid(rxValid),
    .rxByte (rxByte),
    .ctl    (ctl),
    .hits   (hits)
  );

  cmd_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .hits         (hits),
    .ctl          (ctl),
    .captureEn    (captureEn),
    .acqResetPulse(acqResetPulse)
  );
endmodule

// File: tb/tb_cmd_decoder.sv
module tb_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       captureEn, acqResetPulse;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_decoder dut (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxByte(rxByte),
    .captureEn(captureEn), .acqResetPulse(acqResetPulse)
  );

  // {req[3:0], valid, byte[7:0], expEn, expPulse}
  localparam int NV = 50;
  localparam logic [14:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'hAA, 1'b0, 1'b0}, {4'd2, 1'b1, 8'h55, 1'b0, 1'b0},
    {4'd2, 1'b1, 8'hEE, 1'b0, 1'b0}, {4'd3, 1'b1, 8'hA0, 1'b1, 1'b0},  // R3 serial start
    {4'd3, 1'b0, 8'hA0, 1'b1, 1'b0}, {4'd3, 1'b0, 8'h00, 1'b1, 1'b0},  // R3 held
    {4'd8, 1'b1, 8'hAA, 1'b1, 1'b0}, {4'd8, 1'b1, 8'h55, 1'b1, 1'b0},
    {4'd8, 1'b1, 8'hEE, 1'b1, 1'b0}, {4'd8, 1'b1, 8'hC0, 1'b1, 1'b0},  // R8 near miss
    {4'd9, 1'b1, 8'hAA, 1'b1, 1'b0}, {4'd9, 1'b1, 8'h55, 1'b1, 1'b0},
    {4'd9, 1'b1, 8'hFF, 1'b1, 1'b0}, {4'd4, 1'b1, 8'hB1, 1'b0, 1'b0},  // R4/R9 net stop
    {4'd2, 1'b1, 8'h12, 1'b0, 1'b0}, {4'd2, 1'b1, 8'hAA, 1'b0, 1'b0},  // R2 junk prefix
    {4'd2, 1'b1, 8'hAA, 1'b0, 1'b0}, {4'd2, 1'b1, 8'h55, 1'b0, 1'b0},
    {4'd2, 1'b1, 8'hFF, 1'b0, 1'b0}, {4'd9, 1'b1, 8'hA0, 1'b1, 1'b0},  // R9 net start
    {4'd7, 1'b1, 8'hAA, 1'b1, 1'b0}, {4'd7, 1'b1, 8'h55, 1'b1, 1'b0},  // R7 back to back
    {4'd7, 1'b1, 8'hEE, 1'b1, 1'b0}, {4'd6, 1'b1, 8'hA0, 1'b1, 1'b0},  // R6 start while on
    {4'd6, 1'b0, 8'h00, 1'b1, 1'b0},
    {4'd7, 1'b1, 8'hAA, 1'b1, 1'b0}, {4'd7, 1'b1, 8'h55, 1'b1, 1'b0},
    {4'd7, 1'b1, 8'hEE, 1'b1, 1'b0}, {4'd5, 1'b1, 8'hC1, 1'b0, 1'b1},  // R5 serial reset
    {4'd5, 1'b0, 8'h00, 1'b0, 1'b0}, {4'd5, 1'b0, 8'h00, 1'b0, 1'b0},  // R5 single pulse
    {4'd6, 1'b1, 8'hAA, 1'b0, 1'b0}, {4'd6, 1'b1, 8'h55, 1'b0, 1'b0},
    {4'd6, 1'b1, 8'hEE, 1'b0, 1'b0}, {4'd6, 1'b1, 8'hB1, 1'b0, 1'b0},  // R6 stop while off
    {4'd8, 1'b1, 8'hAA, 1'b0, 1'b0}, {4'd8, 1'b0, 8'hAA, 1'b0, 1'b0},  // R8 gaps w/ garbage
    {4'd8, 1'b1, 8'h55, 1'b0, 1'b0}, {4'd8, 1'b0, 8'hC1, 1'b0, 1'b0},
    {4'd8, 1'b1, 8'hEE, 1'b0, 1'b0}, {4'd8, 1'b0, 8'hB1, 1'b0, 1'b0},
    {4'd8, 1'b1, 8'hA0, 1'b1, 1'b0},
    {4'd9, 1'b1, 8'hAA, 1'b1, 1'b0}, {4'd9, 1'b1, 8'h55, 1'b1, 1'b0},
    {4'd9, 1'b1, 8'hFF, 1'b1, 1'b0}, {4'd5, 1'b1, 8'hC1, 1'b0, 1'b1},  // R5/R9 net reset
    {4'd5, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'd8, 1'b1, 8'hA0, 1'b0, 1'b0}, {4'd8, 1'b1, 8'hC1, 1'b0, 1'b0},
    {4'd8, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic expEn, input logic expP);
    checks++;
    if (captureEn !== expEn || acqResetPulse !== expP) begin
      failures++;
      $display("FAIL %s: en/pulse actual=%b%b expected=%b%b",
               req, captureEn, acqResetPulse, expEn, expP);
    end
  endtask

  task automatic sendByte(input logic v, input logic [7:0] b);
    rxValid = v;
    rxByte  = b;
    @(posedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0, 1'b0);            // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      sendByte(VEC[i][10], VEC[i][9:2]);
      check($sformatf("R%0d", VEC[i][14:11]), VEC[i][1], VEC[i][0]);
    end

    // R1: reset in the middle of a start word discards its prefix
    sendByte(1'b1, 8'hAA); sendByte(1'b1, 8'h55); sendByte(1'b1, 8'hEE);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst = 1'b0;
    sendByte(1'b1, 8'hA0);
    check("R1", 1'b0, 1'b0);

    // R1: reset while capture is enabled
    sendByte(1'b1, 8'hAA); sendByte(1'b1, 8'h55); sendByte(1'b1, 8'hFF); sendByte(1'b1, 8'hA0);
    check("R3", 1'b1, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst = 1'b0;
    sendByte(1'b0, 8'h00);
    check("R1", 1'b0, 1'b0);

    // R9: mixed families, serial start then network stop
    sendByte(1'b1, 8'hAA); sendByte(1'b1, 8'h55); sendByte(1'b1, 8'hEE); sendByte(1'b1, 8'hA0);
    check("R9", 1'b1, 1'b0);
    sendByte(1'b1, 8'hAA); sendByte(1'b1, 8'h55); sendByte(1'b1, 8'hFF);
    check("R7", 1'b1, 1'b0);
    sendByte(1'b1, 8'hB1);
    check("R9", 1'b0, 1'b0);

    done = 1;
    finishRun();
  end
endmodule